// File: doc/BRIEF.md
# Serial Command Register Bank with Frame Watchdog

This block receives 16-bit command frames from an SPI master. It decodes them into the configuration registers of a multi-output switch controller and drives the register contents out in parallel to the rest of the controller. The SPI pins are synchronised into the system clock domain. A frame takes effect only when chip select is released after exactly sixteen serial clock edges. The frame's address field picks the target register. One address holds two registers, and a data bit chooses between them.

Each frame also carries a watchdog bit. The master has to flip this bit from one committed frame to the next, and it has to do so before a programmable number of system clock cycles runs out. If it does not, the block enters a fail state. In that state every register is cleared and frames are refused until one arrives with the watchdog bit set. The block also emits a one-cycle synchronisation pulse on each chip-select release, when that feature has been enabled. The controller's PWM generators use this pulse to line up their phases.

Top module: `spi_cmd_wdog`

## Requirements
- R1: While reset is asserted, and right after it, every register output is zero and `failMode` and `syncPulse` are low.
- R2: A frame is committed only when `csN` rises after exactly 16 rising edges of `sclk`. Shorter or longer frames write nothing and do not feed the watchdog.
- R3: Bits arrive MSB first in SPI mode 0. Frame bits 15..11 are the address and bit 10 is the watchdog bit. Addresses other than 0, 1 and 2 change no register.
- R4: Address 0 loads the setup register from frame bits 7..0. `statusSel` comes from bits 1..0 and `senseSel` from bits 4..2 (0 none, 1 to 5 output 1 to 5, 6 external switch, 7 temperature). `bulbProfile` comes from bit 5, `syncEn` from bit 6 and `extCtrlEn` from bit 7.
- R5: Address 1 loads `openLoadMode` from frame bits NOUT-1..0.
- R6: Address 2 loads `prescEn` from bits NOUT-1..0 when bit 9 is 0. It loads `slewFast` from the same bits when bit 9 is 1, and leaves the other register unchanged.
- R7: Each `csN` rise gives exactly one `syncPulse` cycle when `syncEn` was 1 before that frame. No pulse is given when it was 0.
- R8: A committed frame whose watchdog bit differs from that of the previous committed frame restarts the watchdog. The bit is taken as 0 after reset. After WDOG_CYCLES cycles without a restart, `failMode` goes high. Frames that repeat the bit do not restart the watchdog.
- R9: Entering fail mode clears all registers. While in fail mode, frames with the watchdog bit at 0 are ignored.
- R10: In fail mode, a committed frame with the watchdog bit at 1 clears `failMode` and is decoded like a normal frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | SPI serial clock, idle low |
| csN | input | 1 | SPI chip select, active low |
| mosi | input | 1 | SPI data in, MSB first |
| statusSel | output | 2 | Status word chosen for the next frame |
| senseSel | output | 3 | Current/temperature sense selector |
| bulbProfile | output | 1 | Bulb profile choice for output 2 |
| syncEn | output | 1 | PWM phase synchronisation enable |
| extCtrlEn | output | 1 | External input controls output 4 |
| openLoadMode | output | NOUT | Per-output open-load detection mode |
| prescEn | output | NOUT | Per-output PWM clock prescaler enable |
| slewFast | output | NOUT | Per-output fast slew enable |
| syncPulse | output | 1 | One-cycle pulse on chip-select release |
| failMode | output | 1 | Watchdog fail state |

## Verification
A chip-select rise reaches the register outputs on the third system clock edge after the pin changes: two edges go through the synchroniser and one into the register. The synchronisation pulse appears on that same edge. The bench therefore waits six clock cycles after releasing chip select before it samples anything, and it always samples on the falling clock edge. Watchdog expiry is checked only after margins of at least 50 cycles beyond WDOG_CYCLES from the last restarting frame. The opposite case, frames kept well inside the window, is checked for staying out of fail mode.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  localparam int FRAME_W   = 16;
  localparam int ADDR_HI   = 15;
  localparam int ADDR_LO   = 11;
  localparam int WD_BIT    = 10;
  localparam int BANK_BIT  = 9;
  localparam int PAYLOAD_W = 8;
  localparam int CNT_W     = $clog2(FRAME_W + 2);

  localparam logic [ADDR_HI-ADDR_LO:0] ADDR_SETUP = 5'd0;
  localparam logic [ADDR_HI-ADDR_LO:0] ADDR_OPEN  = 5'd1;
  localparam logic [ADDR_HI-ADDR_LO:0] ADDR_DRIVE = 5'd2;

  typedef struct packed {
    logic                 wrSetup;
    logic                 wrOpen;
    logic                 wrPresc;
    logic                 wrSlew;
    logic                 clearAll;
    logic                 csEdge;
    logic [PAYLOAD_W-1:0] payload;
  } ctrlStrobes_t;
endpackage

// File: rtl/spi_cmd_ctrl.sv
module spi_cmd_ctrl
  import spi_cmd_pkg::*;
#(
  parameter int WDOG_CYCLES = 1000
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         sclk,
  input  logic         csN,
  input  logic         mosi,
  output ctrlStrobes_t stb,
  output logic         failMode
);
  localparam int WDW = $clog2(WDOG_CYCLES);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] SAT_CNT  = CNT_W'(FRAME_W + 1);

  logic [2:0] sclkSync, csSync;
  logic [1:0] mosiSync;
  logic [FRAME_W-1:0] shiftReg;
  logic [CNT_W-1:0] bitCnt;
  logic [WDW-1:0] wdCnt;
  logic wdLast;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkSync <= '0;
      csSync   <= '1;
      mosiSync <= '0;
    end else begin
      sclkSync <= {sclkSync[1:0], sclk};
      csSync   <= {csSync[1:0], csN};
      mosiSync <= {mosiSync[0], mosi};
    end
  end

  logic sclkRise, csRise, csFall, csLow;
  assign sclkRise = sclkSync[1] & ~sclkSync[2];
  assign csRise   = csSync[1] & ~csSync[2];
  assign csFall   = ~csSync[1] & csSync[2];
  assign csLow    = ~csSync[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      bitCnt   <= '0;
    end else if (csFall) begin
      bitCnt <= '0;
    end else if (csLow && sclkRise) begin
      shiftReg <= {shiftReg[FRAME_W-2:0], mosiSync[1]};
      if (bitCnt != SAT_CNT) bitCnt <= bitCnt + 1'b1;
    end
  end

  logic frameValid, wdBit, accept, feed, expire;
  logic [ADDR_HI-ADDR_LO:0] addr;
  assign frameValid = csRise && (bitCnt == FULL_CNT);
  assign wdBit      = shiftReg[WD_BIT];
  assign addr       = shiftReg[ADDR_HI:ADDR_LO];
  assign accept     = frameValid && (!failMode || wdBit);
  assign feed       = frameValid && (wdBit != wdLast);
  assign expire     = !failMode && !feed && (wdCnt == WDW'(WOG_LAST));
  localparam int WOG_LAST = WDOG_CYCLES - 1;

  always_comb begin
    stb          = '0;
    stb.payload  = shiftReg[PAYLOAD_W-1:0];
    stb.csEdge   = csRise;
    stb.clearAll = expire;
    stb.wrSetup  = accept && (addr == ADDR_SETUP);
    stb.wrOpen   = accept && (addr == ADDR_OPEN);
    stb.wrPresc  = accept && (addr == ADDR_DRIVE) && !shiftReg[BANK_BIT];
    stb.wrSlew   = accept && (addr == ADDR_DRIVE) && shiftReg[BANK_BIT];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wdCnt    <= '0;
      wdLast   <= 1'b0;
      failMode <= 1'b0;
    end else if (failMode) begin
      if (frameValid && wdBit) begin
        failMode <= 1'b0;
        wdLast   <= 1'b1;
        wdCnt    <= '0;
      end
    end else begin
      if (frameValid) wdLast <= wdBit;
      if (feed) wdCnt <= '0;
      else if (expire) begin
        failMode <= 1'b1;
        wdCnt    <= '0;
      end else wdCnt <= wdCnt + 1'b1;
    end
  end

  a_r2_count_saturates: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= SAT_CNT);
  a_r8_window_bound: assert property (@(posedge clk) disable iff (!rstN)
    wdCnt <= WDW'(WOG_LAST));
  a_r6_single_target: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.wrSetup, stb.wrOpen, stb.wrPresc, stb.wrSlew}));
  a_r10_exit_needs_wd: assert property (@(posedge clk) disable iff (!rstN)
    $fell(failMode) |-> $past(frameValid && wdBit));
endmodule

// File: rtl/spi_cmd_regs.sv
module spi_cmd_regs
  import spi_cmd_pkg::*;
#(
  parameter int NOUT = 5
) (
  input  logic            clk,
  input  logic            rstN,
  input  ctrlStrobes_t    stb,
  input  logic            failIn,
  output logic [1:0]      statusSel,
  output logic [2:0]      senseSel,
  output logic            bulbProfile,
  output logic            syncEn,
  output logic            extCtrlEn,
  output logic [NOUT-1:0] openLoadMode,
  output logic [NOUT-1:0] prescEn,
  output logic [NOUT-1:0] slewFast,
  output logic            syncPulse
);
  logic [PAYLOAD_W-1:0] setupReg;
  logic [NOUT-1:0] openReg, prescReg, slewReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      setupReg  <= '0;
      openReg   <= '0;
      prescReg  <= '0;
      slewReg   <= '0;
      syncPulse <= 1'b0;
    end else begin
      syncPulse <= stb.csEdge && setupReg[6];
      if (stb.clearAll) begin
        setupReg <= '0;
        openReg  <= '0;
        prescReg <= '0;
        slewReg  <= '0;
      end else begin
        if (stb.wrSetup) setupReg <= stb.payload;
        if (stb.wrOpen)  openReg  <= stb.payload[NOUT-1:0];
        if (stb.wrPresc) prescReg <= stb.payload[NOUT-1:0];
        if (stb.wrSlew)  slewReg  <= stb.payload[NOUT-1:0];
      end
    end
  end

  assign statusSel    = setupReg[1:0];
  assign senseSel     = setupReg[4:2];
  assign bulbProfile  = setupReg[5];
  assign syncEn       = setupReg[6];
  assign extCtrlEn    = setupReg[7];
  assign openLoadMode = openReg;
  assign prescEn      = prescReg;
  assign slewFast     = slewReg;

  a_r9_fail_regs_clear: assert property (@(posedge clk) disable iff (!rstN)
    (failIn && $past(failIn)) |->
      (setupReg == '0 && openReg == '0 && prescReg == '0 && slewReg == '0));
  a_r7_pulse_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    syncPulse |=> !syncPulse);
endmodule

// File: rtl/spi_cmd_wdog.sv
module spi_cmd_wdog
  import spi_cmd_pkg::*;
#(
  parameter int NOUT        = 5,
  parameter int WDOG_CYCLES = 1000
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            sclk,
  input  logic            csN,
  input  logic            mosi,
  output logic [1:0]      statusSel,
  output logic [2:0]      senseSel,
  output logic            bulbProfile,
  output logic            syncEn,
  output logic            extCtrlEn,
  output logic [NOUT-1:0] openLoadMode,
  output logic [NOUT-1:0] prescEn,
  output logic [NOUT-1:0] slewFast,
  output logic            syncPulse,
  output logic            failMode
);
  ctrlStrobes_t stb;

  spi_cmd_ctrl #(.WDOG_CYCLES(WDOG_CYCLES)) ctrl (
    .clk(clk), .rstN(rstN), .sclk(sclk), .csN(csN), .mosi(mosi),
    .stb(stb), .failMode(failMode)
  );

  spi_cmd_regs #(.NOUT(NOUT)) regs (
    .clk(clk), .rstN(rstN), .stb(stb), .failIn(failMode),
    .statusSel(statusSel), .senseSel(senseSel), .bulbProfile(bulbProfile),
    .syncEn(syncEn), .extCtrlEn(extCtrlEn), .openLoadMode(openLoadMode),
    .prescEn(prescEn), .slewFast(slewFast), .syncPulse(syncPulse)
  );
endmodule

// File: tb/spi_cmd_wdog_test.sv
module spi_cmd_wdog_test;
  localparam int NOUT = 5;
  localparam int WDOG = 1000;

  logic clk = 1'b0, rstN = 1'b0, sclk = 1'b0, csN = 1'b1, mosi = 1'b0;
  logic [1:0] statusSel;
  logic [2:0] senseSel;
  logic bulbProfile, syncEn, extCtrlEn, syncPulse, failMode;
  logic [NOUT-1:0] openLoadMode, prescEn, slewFast;

  int checkCount = 0, failCount = 0, pulses = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  spi_cmd_wdog #(.NOUT(NOUT), .WDOG_CYCLES(WDOG)) uut (
    .clk(clk), .rstN(rstN), .sclk(sclk), .csN(csN), .mosi(mosi),
    .statusSel(statusSel), .senseSel(senseSel), .bulbProfile(bulbProfile),
    .syncEn(syncEn), .extCtrlEn(extCtrlEn), .openLoadMode(openLoadMode),
    .prescEn(prescEn), .slewFast(slewFast), .syncPulse(syncPulse),
    .failMode(failMode)
  );

  always @(negedge clk) if (syncPulse) pulses++;

  // Rows: {frame, setup bits 7..0, openLoadMode, prescEn, slewFast}
  localparam logic [38:0] VEC [0:7] = '{
    {16'h04A5, 8'hA5, 5'h00, 5'h00, 5'h00},
    {16'h0815, 8'hA5, 5'h15, 5'h00, 5'h00},
    {16'h140B, 8'hA5, 5'h15, 5'h0B, 5'h00},
    {16'h121C, 8'hA5, 5'h15, 5'h0B, 5'h1C},
    {16'h1CFF, 8'hA5, 5'h15, 5'h0B, 5'h1C},  // address 3: ignored (R3)
    {16'h005A, 8'h5A, 5'h15, 5'h0B, 5'h1C},
    {16'h0C0A, 8'h5A, 5'h0A, 5'h0B, 5'h1C},
    {16'h101F, 8'h5A, 5'h0A, 5'h1F, 5'h1C}
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendBits(input logic [31:0] word, input int n);
    csN = 1'b0;
    tick(2);
    for (int i = n - 1; i >= 0; i--) begin
      mosi = word[i];
      tick(2);
      sclk = 1'b1;
      tick(2);
      sclk = 1'b0;
    end
    tick(2);
    csN = 1'b1;
    tick(6);
  endtask

  task automatic check(input string req, input int actual, input int expected);
    checkCount++;
    if (actual != expected) begin
      failCount++;
      $display("FAIL %s actual=%0h expected=%0h", req, actual, expected);
    end
  endtask

  function automatic int setupBits();
    return int'({extCtrlEn, syncEn, bulbProfile, senseSel, statusSel});
  endfunction

  task automatic checkAllClear(input string req);
    check(req, setupBits(), 0);
    check(req, int'(openLoadMode), 0);
    check(req, int'(prescEn), 0);
    check(req, int'(slewFast), 0);
  endtask

  initial begin
    int p0;
    tick(4);
    checkAllClear("R1 reset");
    check("R1 fail low", int'(failMode), 0);
    check("R1 pulse low", int'(syncPulse), 0);
    rstN = 1'b1;
    tick(2);

    foreach (VEC[i]) begin
      sendBits({16'h0, VEC[i][38:23]}, 16);
      check("R4 setup", setupBits(), int'(VEC[i][22:15]));
      check("R5 open-load", int'(openLoadMode), int'(VEC[i][14:10]));
      check("R6 prescaler", int'(prescEn), int'(VEC[i][9:5]));
      check("R6 slew", int'(slewFast), int'(VEC[i][4:0]));
      check("R8 no fail", int'(failMode), 0);
    end
    check("R4 sense external", int'(senseSel), 6);
    check("R7 pulses while enabled", pulses, 2);

    sendBits(32'h3C00, 16);  // address 7, wd 1
    check("R3 unknown address", setupBits(), 'h5A);
    check("R7 pulse count", pulses, 3);

    sendBits(32'h0000, 15);
    check("R2 short frame", setupBits(), 'h5A);
    sendBits(32'h00000, 17);
    check("R2 long frame", setupBits(), 'h5A);

    sendBits(32'h0003, 16);  // wd 0, sync disabled
    check("R4 rewrite", setupBits(), 'h03);
    p0 = pulses;

    for (int k = 0; k < 16; k++) sendBits(32'h0800 | k, 16);  // wd stuck at 0
    check("R7 no pulse when disabled", pulses, p0);
    check("R8 stuck wd fails", int'(failMode), 1);
    checkAllClear("R9 cleared");

    sendBits(32'h00FF, 16);
    check("R9 wd0 ignored fail", int'(failMode), 1);
    check("R9 wd0 ignored data", setupBits(), 0);

    sendBits(32'h0441, 16);
    check("R10 exit", int'(failMode), 0);
    check("R10 decoded", setupBits(), 'h41);

    for (int k = 0; k < 16; k++)
      sendBits(32'h0800 | ((k % 2) << 10) | k, 16);
    check("R8 toggling alive", int'(failMode), 0);
    check("R5 last write", int'(openLoadMode), 'h0F);

    tick(WDOG + 100);
    check("R8 idle timeout", int'(failMode), 1);
    checkAllClear("R9 timeout clear");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

  initial begin
    tick(150000);
    if (!done) begin
      checkCount++;
      failCount++;
      $display("FAIL R8 bench watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
      $finish;
    end
  end
endmodule